// File: doc/BRIEF.md
# GPIO Input Qualifier Group

This block conditions a group of asynchronous pad inputs before they reach on-chip peripherals. Each pin has its own two-bit mode. A pin can be resynchronised to the system clock. It can be passed through a sampling window that accepts a new level only after a run of identical samples. It can also bypass all conditioning for a peripheral that resynchronises the signal itself.

All pins of the group share one sampling-period field. From that field a single divider produces a sample tick. Window-mode pins look at their synchronised input only on that tick, so filtering is stronger when the period is longer. Every edge a window pin accepts arrives later by the full window. Any peripheral that senses the pin sees the same delay. A serial clock line that is read back through a long window therefore runs slower than programmed.

Top module: `gpio_qual_group`

## Requirements
- R1: When reset is released, every window-mode output already equals the pin level seen through the synchroniser, with no qualification wait.
- R2: Mode 0 (sync-only) gives an output equal to the pin as it stood two clock edges earlier, so a one-clock pulse passes through.
- R3: Mode 3 (asynchronous) drives the output combinationally from the raw pin, with no delay.
- R4: Mode 1 (three-sample window) changes the output only on the third consecutive sample tick that sees the new synchronised level. With a tick on every clock, an edge that is held long enough appears 5 edges after the pin changes.
- R5: Mode 2 (six-sample window) works like R4 but needs six consecutive ticks, which gives 8 edges of latency with a tick on every clock.
- R6: A period value P of 2 or more gives one sample tick every P clocks, on clock edges P, 2P, 3P and so on, counted from the first edge after reset release. P of 0 or 1 gives a tick on every clock. P=12 ticks once per 12 clocks.
- R7: A run of new-level samples broken by one old-level sample restarts the count. Runs shorter than the window leave the output unchanged.
- R8: The period is shared by all pins. The mode is chosen per pin, and each pin's output depends only on its own pin and mode.
- R9: Falling edges are qualified in the same way as rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_raw | input | NPINS | Asynchronous pad levels |
| mode_sel | input | 2*NPINS | Per-pin mode, pin i in bits [2i+1:2i]: 0 sync, 1 three-sample, 2 six-sample, 3 asynchronous |
| qual_prd | input | PRD_W | Shared sampling period in system clocks |
| pin_out | output | NPINS | Conditioned levels to the peripherals |

## Verification
The asynchronous result is due in the same cycle as the pin change. The sync-only result is due two edges later. A window result is due on the Nth tick at or after the third edge past the change, so its latency depends on P and on the tick phase. Each run counts edges from reset release and changes the pin just after edge 10, so the tick phase is always known. It then records the first edge after which the output moved, at the falling clock edge, and compares that edge count with a tabulated latency. Pulses that are too short, or runs that are broken, must produce no movement at all within a fixed observation window.

// File: rtl/gq_pkg.sv
// Shared definitions for the GPIO input qualifier group.
// Assumes a two-bit per-pin mode field; the encoding is fixed by the pin mux.
package gq_pkg;
    typedef enum logic [1:0] {
        QM_SYNC  = 2'd0,
        QM_WIN3  = 2'd1,
        QM_WIN6  = 2'd2,
        QM_ASYNC = 2'd3
    } qmode_t;

    localparam int WIN_SHORT = 3;
    localparam int WIN_LONG  = 6;
endpackage

// File: rtl/gq_tick_gen.sv
// Sample tick divider shared by a pin group.
// Produces one tick every PRD clocks (every clock for PRD 0 or 1).
// Assumes the period is changed only rarely; a reduced period takes effect
// at once because the compare is "at or above" the limit.
module gq_tick_gen #(
    parameter int PRD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRD_W-1:0] prd,
    output logic             tick
);
    logic [PRD_W-1:0] cnt;
    logic [PRD_W-1:0] lim;

    // Last count value before the tick, treating 0 as 1
    always_comb begin
        lim  = (prd == '0) ? '0 : prd - 1'b1;
        tick = (cnt >= lim);
    end

    // Free-running count, cleared on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/gq_sync2.sv
// Two-flop synchroniser for one asynchronous pad input.
// The flops are intentionally not reset so that the pin level is already
// visible while reset is held; this is what lets the qualifier preload.
module gq_sync2 (
    input  logic clk,
    input  logic d_async,
    output logic q_sync
);
    logic meta;

    // Two-stage capture into the clock domain
    always_ff @(posedge clk) begin
        meta   <= d_async;
        q_sync <= meta;
    end
endmodule

// File: rtl/gq_pin_qual.sv
// Per-pin qualifier: synchroniser, sample-window filter and mode select.
// Assumes the tick comes from the group divider. In window modes the held
// level moves only after WIN_SHORT or WIN_LONG consecutive disagreeing
// samples; in other modes the held level tracks the synchroniser so a
// switch into a window mode starts from the present level.
module gq_pin_qual
    import gq_pkg::*;
#(
    localparam int RUN_W = $clog2(WIN_LONG + 1)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   raw,
    input  qmode_t mode,
    input  logic   tick,
    output logic   sync_o,
    output logic   out
);
    logic             s;
    logic             held;
    logic [RUN_W-1:0] run;
    logic [RUN_W-1:0] need_m1;
    logic             win_mode;

    gq_sync2 u_sync (
        .clk     (clk),
        .d_async (raw),
        .q_sync  (s)
    );

    // Window length for the selected mode, less one
    always_comb begin
        win_mode = (mode == QM_WIN3) || (mode == QM_WIN6);
        need_m1  = (mode == QM_WIN6) ? RUN_W'(WIN_LONG - 1) : RUN_W'(WIN_SHORT - 1);
    end

    // Held level and run length of consecutive disagreeing samples
    always_ff @(posedge clk) begin
        if (!rst_n || !win_mode) begin
            held <= s;
            run  <= '0;
        end else if (tick) begin
            if (s == held) begin
                run <= '0;
            end else if (run >= need_m1) begin
                held <= s;
                run  <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end

    // Output selection by mode
    always_comb begin
        unique case (mode)
            QM_ASYNC: out = raw;
            QM_SYNC:  out = s;
            default:  out = held;
        endcase
    end

    assign sync_o = s;
endmodule

// File: rtl/gpio_qual_group.sv
// Group of NPINS input qualifiers sharing one sampling-period divider.
// Assumes mode_sel packs two bits per pin, pin i in bits [2i+1:2i].
module gpio_qual_group
    import gq_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int PRD_W = 8,
    localparam int MODE_W = 2 * NPINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_raw,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic [PRD_W-1:0]  qual_prd,
    output logic [NPINS-1:0]  pin_out
);
    logic             smp_tick;
    logic [NPINS-1:0] pin_sync;

    gq_tick_gen #(.PRD_W(PRD_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .prd   (qual_prd),
        .tick  (smp_tick)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gq_pin_qual u_pin (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (pin_raw[i]),
            .mode   (qmode_t'(mode_sel[2*i +: 2])),
            .tick   (smp_tick),
            .sync_o (pin_sync[i]),
            .out    (pin_out[i])
        );
    end
endmodule

// File: rtl/gpio_qual_group_chk.sv
// Assertion checker for gpio_qual_group, attached by bind below.
module gpio_qual_group_chk #(
    parameter int NPINS = 8,
    parameter int PRD_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NPINS-1:0]   pin_raw,
    input logic [2*NPINS-1:0] mode_sel,
    input logic [PRD_W-1:0]   qual_prd,
    input logic [NPINS-1:0]   pin_out,
    input logic               smp_tick,
    input logic [NPINS-1:0]   pin_sync
);
    logic [1:0]       age;
    logic [PRD_W-1:0] gap;
    logic [PRD_W-1:0] lim;

    // Cycles since reset release, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)        age <= '0;
        else if (age != 3) age <= age + 1'b1;
    end

    // Cycles since the last observed tick
    always_ff @(posedge clk) begin
        if (!rst_n || smp_tick) gap <= '0;
        else                    gap <= gap + 1'b1;
    end

    assign lim = (qual_prd == '0) ? '0 : qual_prd - 1'b1;

    // R6
    tick_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tick |-> gap >= lim);
    // R6
    tick_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap >= lim |-> smp_tick);

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        // R3
        async_pass_chk: assert property (@(posedge clk)
            mode_sel[2*i +: 2] == 2'd3 |-> pin_out[i] == pin_raw[i]);
        // R2
        sync_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_sel[2*i +: 2] == 2'd0 && age >= 2) |-> pin_out[i] == $past(pin_raw[i], 2));
        // R4 R5
        win_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 1 && (mode_sel[2*i +: 2] == 2'd1 || mode_sel[2*i +: 2] == 2'd2)
             && $stable(mode_sel[2*i +: 2]) && pin_out[i] != $past(pin_out[i]))
            |-> $past(smp_tick));
        // R9
        win_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 1 && (mode_sel[2*i +: 2] == 2'd1 || mode_sel[2*i +: 2] == 2'd2)
             && $stable(mode_sel[2*i +: 2]) && pin_out[i] != $past(pin_out[i]))
            |-> pin_out[i] == $past(pin_sync[i]));
        // R1
        reset_load_chk: assert property (@(posedge clk)
            ($rose(rst_n) && (mode_sel[2*i +: 2] == 2'd1 || mode_sel[2*i +: 2] == 2'd2))
            |-> pin_out[i] == $past(pin_sync[i]));
    end
endmodule

bind gpio_qual_group gpio_qual_group_chk #(.NPINS(NPINS), .PRD_W(PRD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_raw  (pin_raw),
    .mode_sel (mode_sel),
    .qual_prd (qual_prd),
    .pin_out  (pin_out),
    .smp_tick (smp_tick),
    .pin_sync (pin_sync)
);

// File: tb/test_gpio_qual_group.sv
module test_gpio_qual_group;
    localparam int NPINS = 8;
    localparam int PRD_W = 8;
    localparam int OBS   = 120;
    localparam int NVEC  = 15;
    localparam int NEVER = 255;

    logic              clk = 0;
    logic              rst_n = 0;
    logic [NPINS-1:0]  pin_raw = '0;
    logic [2*NPINS-1:0] mode_sel = '0;
    logic [PRD_W-1:0]  qual_prd = '0;
    logic [NPINS-1:0]  pin_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    gpio_qual_group #(.NPINS(NPINS), .PRD_W(PRD_W)) i_gpio_qual_group (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_raw),
        .mode_sel (mode_sel),
        .qual_prd (qual_prd),
        .pin_out  (pin_out)
    );

    // {pin[3], mode[2], prd[8], hold[8], latency[8]}; hold 255 = held; latency 255 = rejected
    localparam logic [28:0] VEC [NVEC] = '{
        {3'd0, 2'd0, 8'd5,  8'd255, 8'd2},   // R2 level
        {3'd1, 2'd0, 8'd0,  8'd1,   8'd2},   // R2 one-clock pulse
        {3'd2, 2'd3, 8'd7,  8'd255, 8'd0},   // R3
        {3'd3, 2'd1, 8'd0,  8'd255, 8'd5},   // R4
        {3'd4, 2'd1, 8'd1,  8'd255, 8'd5},   // R6 P=1
        {3'd5, 2'd1, 8'd0,  8'd2,   8'd255}, // R4 short
        {3'd6, 2'd1, 8'd0,  8'd3,   8'd5},   // R4 exact
        {3'd7, 2'd2, 8'd0,  8'd255, 8'd8},   // R5
        {3'd0, 2'd2, 8'd0,  8'd5,   8'd255}, // R5 short
        {3'd1, 2'd2, 8'd0,  8'd6,   8'd8},   // R5 exact
        {3'd2, 2'd1, 8'd4,  8'd255, 8'd14},  // R6 P=4
        {3'd3, 2'd1, 8'd4,  8'd11,  8'd255}, // R6 two ticks only
        {3'd4, 2'd1, 8'd4,  8'd12,  8'd14},  // R6 three ticks
        {3'd5, 2'd2, 8'd12, 8'd255, 8'd74},  // R6 P=12
        {3'd6, 2'd2, 8'd3,  8'd255, 8'd20}   // R6 P=3
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset for 4 edges, release at a falling edge, then advance to just after edge 10
    task automatic start_run(input logic [PRD_W-1:0] prd);
        @(negedge clk);
        rst_n = 0;
        qual_prd = prd;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (10) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #900000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int first;
        // R1: pin high through reset, window modes output high at release
        pin_raw = 8'h03;
        mode_sel = {12'h000, 2'd2, 2'd1};
        qual_prd = 8'd12;
        repeat (4) @(negedge clk);
        rst_n = 1;
        #1;
        check(pin_out[0] == 1'b1, "R1 win3", pin_out[0], 1);
        check(pin_out[1] == 1'b1, "R1 win6", pin_out[1], 1);

        // Table walk: one pin flipped, all others sync-only at 0
        for (int v = 0; v < NVEC; v++) begin
            int pin;
            int md;
            int hold;
            int lat;
            pin  = int'(VEC[v][28:26]);
            md   = int'(VEC[v][25:24]);
            hold = int'(VEC[v][15:8]);
            lat  = int'(VEC[v][7:0]);
            pin_raw = '0;
            mode_sel = '0;
            mode_sel[2*pin +: 2] = md[1:0];
            start_run(VEC[v][23:16]);
            check(pin_out == '0, "R1 idle", pin_out, 0);
            pin_raw[pin] = 1'b1;
            first = NEVER;
            #1;
            if (pin_out[pin]) first = 0;
            for (int k = 1; k <= OBS; k++) begin
                @(negedge clk);
                if (pin_out[pin] && first == NEVER) first = k;
                if (k == hold) pin_raw[pin] = 1'b0;
            end
            check(first == lat, $sformatf("R%0d vec%0d latency", (md == 3) ? 3 : (md == 0) ? 2 : (md == 1) ? 4 : 5, v), first, lat);
            check((pin_out & ~(8'(1) << pin)) == '0, "R8 other pins", pin_out, 0);
        end

        // R8: four pins in four modes flipped together, P=0
        begin
            int t [4];
            int ex [4];
            ex = '{2, 5, 8, 0};
            pin_raw = '0;
            mode_sel = {8'h00, 2'd3, 2'd2, 2'd1, 2'd0};
            start_run(8'd0);
            pin_raw[3:0] = 4'hF;
            for (int j = 0; j < 4; j++) t[j] = NEVER;
            #1;
            for (int j = 0; j < 4; j++) if (pin_out[j] && t[j] == NEVER) t[j] = 0;
            for (int k = 1; k <= 20; k++) begin
                @(negedge clk);
                for (int j = 0; j < 4; j++) if (pin_out[j] && t[j] == NEVER) t[j] = k;
            end
            for (int j = 0; j < 4; j++) check(t[j] == ex[j], "R8 concurrent", t[j], ex[j]);
        end

        // R9: falling edge through three-sample window, P=0
        pin_raw = 8'h01;
        mode_sel = 16'h0001;
        start_run(8'd0);
        check(pin_out[0] == 1'b1, "R9 start high", pin_out[0], 1);
        pin_raw[0] = 1'b0;
        first = NEVER;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (!pin_out[0] && first == NEVER) first = k;
        end
        check(first == 5, "R9 fall latency", first, 5);

        // R7: high 2, low 1, high 2 in three-sample mode must be rejected
        pin_raw = '0;
        mode_sel = 16'h0001;
        start_run(8'd0);
        pin_raw[0] = 1'b1;
        first = NEVER;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (pin_out[0] && first == NEVER) first = k;
            if (k == 2) pin_raw[0] = 1'b0;
            if (k == 3) pin_raw[0] = 1'b1;
            if (k == 5) pin_raw[0] = 1'b0;
        end
        check(first == NEVER, "R7 broken run", first, NEVER);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule